// File: doc/BRIEF.md
# SPI Master Engine with Programmable Transfer Delays

This block is the serial side of a host-to-SPI bridge. The host side hands it a transfer command that carries a byte count and a transfer mode. It then supplies outgoing bytes on a valid/ready stream and receives incoming bytes as one-cycle valid pulses. The engine drives the serial clock, the outgoing data line and one of several active-low chip selects, and it samples the incoming data line.

Every setting is captured when a command is accepted. The settings are the chip-select index, one of eight power-of-two clock rates, clock polarity and phase, the ready-to-read polarity, and three delays. The delays are counted in 10 µs ticks. The post-assert delay runs between chip-select assertion and the first clock edge. The inter-byte delay runs between bytes. The pre-deassert delay runs between the last clock edge and the release of the chip select.

In the gated-read mode, a byte only begins while the synchronised ready-to-read input is at its active level. An activity output rests high while the engine is idle and toggles at a slow fixed rate while a transfer is running. A one-cycle done pulse marks the end of each transfer.

Top module: `spi_delay_master`

## Requirements
- R1: A command is accepted only while `cmd_ready` is high, which is only when the engine is idle. All configuration inputs are captured at acceptance, and changing them during a transfer has no effect on that transfer.
- R2: Chip selects are active low. If `cfg_cs_sel` is below NUM_CS, exactly output `cs_n[cfg_cs_sel]` is low from the cycle after acceptance until the transfer ends. Any other index leaves all chip selects high.
- R3: The SCK half period is BASE_HALF shifted left by `cfg_rate` system cycles. Code 0 is the fastest rate and code 7 the slowest, and each step halves the frequency.
- R4: SCK rests at the `cfg_cpol` level whenever no byte is being shifted. With `cfg_cpha`=0 both sides sample on the leading edge. With `cfg_cpha`=1 they sample on the trailing edge. Each byte takes 16 SCK edges.
- R5: Bytes are shifted most-significant bit first on both MOSI and MISO.
- R6: The post-assert, inter-byte and pre-deassert delays each add exactly N × TICK_CYCLES system cycles to their interval, where N is the 16-bit value. N=0 adds nothing.
- R7: `cmd_mode` encodings are 0 = write, 1 = read, 2 = write-read and 3 = gated read. Modes 0 and 2 take one `tx_data` byte per serial byte. Modes 1 and 3 send 0x00. Modes 1, 2 and 3 emit each received byte on `rx_valid`/`rx_data`, and mode 0 emits none.
- R8: In mode 3, a byte starts only while `rtr_in` equals `cfg_rtr_high` (1 = active high). A byte in progress completes even if `rtr_in` deasserts. While the engine waits, SCK stays idle and the chip select stays asserted.
- R9: `activity` is high while idle. During a transfer it toggles every ACT_HALF_CYCLES system cycles.
- R10: `done` is a single-cycle pulse in the cycle in which the chip select returns high and `cmd_ready` returns high.
- R11: A command with `cmd_len`=0 asserts the chip select for exactly (post + pre) × TICK_CYCLES cycles, with no SCK edge and no received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_mode | input | 2 | Transfer mode (R7 encoding) |
| cmd_len | input | LEN_W | Number of bytes in the transfer |
| cfg_cs_sel | input | SEL_W | Index of the chip select to drive |
| cfg_rate | input | 3 | Clock rate code, 0 fastest |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_rtr_high | input | 1 | Active level of the ready-to-read input |
| cfg_dly_post | input | DLY_W | Ticks from chip-select assertion to first clock |
| cfg_dly_byte | input | DLY_W | Ticks between bytes |
| cfg_dly_pre | input | DLY_W | Ticks from last clock edge to chip-select release |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Engine can take an outgoing byte |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| rtr_in | input | 1 | Ready-to-read handshake from the slave |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | NUM_CS | Active-low chip selects |
| activity | output | 1 | Idle-high transfer indicator |
| done | output | 1 | End-of-transfer pulse |

## Verification
Several properties are checked on every cycle:
- at most one chip select is ever low;
- SCK rests at the captured polarity while idle and only moves during a transfer;
- activity stays high across idle stretches;
- done is a lone pulse that coincides with release;
- write mode never produces a received byte, and the engine never offers `tx_ready` while idle.

Other behaviour only the bench scenarios can show. Exact delay lengths are measured against a zero-delay baseline, and the rate-dependent half period is measured directly. Byte contents in all four clock modes are checked against a slave model. The bench also covers stalling and resuming on the ready-to-read input, immunity to configuration changes during a transfer, the zero-length command, and the spacing of activity toggles.

// File: rtl/spi_dm_pkg.sv
// Shared types for the SPI delay master: transfer modes and engine states.
package spi_dm_pkg;

    // Transfer mode as presented on cmd_mode.
    typedef enum logic [1:0] {
        MODE_WRITE    = 2'd0,
        MODE_READ     = 2'd1,
        MODE_WRRD     = 2'd2,
        MODE_RTR_READ = 2'd3
    } xfer_mode_e;

    // Sequencer states of the engine.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POST  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_GAP   = 3'd4,
        ST_PRE   = 3'd5
    } eng_state_e;

endpackage

// File: rtl/spi_dm_timer.sv
// Delay timer: counts load_n ticks of TICK_CYCLES system cycles each.
// expire is high in the last cycle of the interval, so the caller moves on
// exactly load_n*TICK_CYCLES cycles after the load edge. Loading 0 never expires;
// the caller skips zero delays itself.
module spi_dm_timer #(
    parameter int TICK_CYCLES = 480,
    parameter int N_W         = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N_W-1:0] load_n,
    output logic           expire
);
    localparam int SUB_W = $clog2(TICK_CYCLES + 1);
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(TICK_CYCLES - 1);

    logic           run_q;
    logic [N_W-1:0] tick_q;
    logic [SUB_W-1:0] sub_q;

    assign expire = run_q && (tick_q == N_W'(1)) && (sub_q == '0);

    // Tick and sub-tick down-counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            tick_q <= '0;
            sub_q  <= '0;
        end else if (load) begin
            run_q  <= (load_n != '0);
            tick_q <= load_n;
            sub_q  <= SUB_TOP;
        end else if (run_q) begin
            if (sub_q == '0) begin
                sub_q  <= SUB_TOP;
                tick_q <= tick_q - N_W'(1);
                if (tick_q == N_W'(1)) run_q <= 1'b0;
            end else begin
                sub_q <= sub_q - SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_dm_shifter.sv
// Byte shifter: produces 16 SCK edges spaced BASE_HALF<<rate cycles apart,
// shifts tx MSB first and samples MISO per cpha. done pulses the cycle after
// the last edge, when rx_byte already holds the full received byte.
// Assumes cpol/cpha/rate are held stable by the caller during a byte.
module spi_dm_shifter #(
    parameter int BASE_HALF = 2,
    parameter int RATE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        tx_byte,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [RATE_W-1:0] rate,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [7:0]        rx_byte,
    output logic              busy,
    output logic              done
);
    localparam int MAX_HALF = BASE_HALF << ((1 << RATE_W) - 1);
    localparam int DIV_W    = $clog2(MAX_HALF + 1);

    logic [DIV_W-1:0] half_len, div_q;
    logic [3:0]       edge_q;
    logic             phase_q, busy_q, done_q;
    logic [7:0]       sh_q, rx_q;
    logic             do_sample, do_shift;

    assign half_len = DIV_W'(BASE_HALF) << rate;
    assign sck      = cpol ^ phase_q;
    assign mosi     = sh_q[7];
    assign rx_byte  = rx_q;
    assign busy     = busy_q;
    assign done     = done_q;

    // Decide per edge whether it samples MISO or advances MOSI.
    always_comb begin
        do_sample = cpha ? edge_q[0] : !edge_q[0];
        do_shift  = cpha ? (!edge_q[0] && (edge_q != 4'd0)) : edge_q[0];
    end

    // Half-period divider, edge counter and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
            div_q   <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    sh_q    <= tx_byte;
                    div_q   <= half_len - DIV_W'(1);
                    edge_q  <= '0;
                    phase_q <= 1'b0;
                end
            end else if (div_q != '0) begin
                div_q <= div_q - DIV_W'(1);
            end else begin
                div_q   <= half_len - DIV_W'(1);
                phase_q <= ~phase_q;
                edge_q  <= edge_q + 4'd1;
                if (do_sample) rx_q <= {rx_q[6:0], miso};
                if (do_shift)  sh_q <= {sh_q[6:0], 1'b0};
                if (edge_q == 4'd15) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_dm_activity.sv
// Activity indicator: forced high while idle, toggles every HALF_CYCLES
// cycles while busy. The first toggle comes HALF_CYCLES cycles into busy.
module spi_dm_activity #(
    parameter int HALF_CYCLES = 2_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic act
);
    localparam int CNT_W = $clog2(HALF_CYCLES + 1);
    logic [CNT_W-1:0] cnt_q;

    // Toggle timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            act   <= 1'b1;
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(HALF_CYCLES - 1)) begin
            cnt_q <= '0;
            act   <= ~act;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_delay_master.sv
// SPI master engine with post-assert, inter-byte and pre-deassert delays.
// Sequencer: IDLE -> POST -> (WAIT -> SHIFT -> GAP)* -> PRE -> IDLE, with
// zero-length delays skipped. Configuration is captured at command accept.
// Assumes rtr_in is asynchronous (it is synchronised here) and that
// NUM_CS <= 2**SEL_W.
module spi_delay_master
    import spi_dm_pkg::*;
#(
    parameter int NUM_CS          = 11,
    parameter int SEL_W           = 4,
    parameter int LEN_W           = 16,
    parameter int DLY_W           = 16,
    parameter int BASE_HALF       = 2,
    parameter int TICK_CYCLES     = 480,
    parameter int ACT_HALF_CYCLES = 2_400_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SEL_W-1:0]  cfg_cs_sel,
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_rtr_high,
    input  logic [DLY_W-1:0]  cfg_dly_post,
    input  logic [DLY_W-1:0]  cfg_dly_byte,
    input  logic [DLY_W-1:0]  cfg_dly_pre,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [7:0]        tx_data,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    input  logic              rtr_in,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              activity,
    output logic              done
);
    eng_state_e       state_q, state_d;
    xfer_mode_e       mode_q;
    logic [SEL_W-1:0] sel_q;
    logic [2:0]       rate_q;
    logic             cpol_q, cpha_q, rtr_high_q;
    logic [DLY_W-1:0] post_q, gap_q, pre_q;
    logic [LEN_W-1:0] left_q;
    logic             rtr_s1, rtr_s2;
    logic             needs_tx, reads, rtr_ok, byte_go;
    logic             t_load, t_expire, done_set, accept;
    logic [DLY_W-1:0] t_n;
    logic             sh_done, sh_busy;
    logic [7:0]       sh_rx;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_ready && cmd_valid;
    assign needs_tx  = (mode_q == MODE_WRITE) || (mode_q == MODE_WRRD);
    assign reads     = (mode_q != MODE_WRITE);
    assign rtr_ok    = (rtr_s2 == rtr_high_q);
    assign tx_ready  = (state_q == ST_WAIT) && needs_tx;
    assign byte_go   = (state_q == ST_WAIT) &&
                       (needs_tx ? tx_valid : ((mode_q != MODE_RTR_READ) || rtr_ok));

    // Two-flop synchroniser for the ready-to-read input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtr_s1 <= 1'b0;
            rtr_s2 <= 1'b0;
        end else begin
            rtr_s1 <= rtr_in;
            rtr_s2 <= rtr_s1;
        end
    end

    // Next-state logic with zero-delay skipping and timer loads.
    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_n      = '0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                if (cfg_dly_post != '0) begin
                    state_d = ST_POST; t_load = 1'b1; t_n = cfg_dly_post;
                end else if (cmd_len != '0) begin
                    state_d = ST_WAIT;
                end else if (cfg_dly_pre != '0) begin
                    state_d = ST_PRE; t_load = 1'b1; t_n = cfg_dly_pre;
                end else begin
                    done_set = 1'b1;
                end
            end
            ST_POST: if (t_expire) begin
                if (left_q != '0) begin
                    state_d = ST_WAIT;
                end else if (pre_q != '0) begin
                    state_d = ST_PRE; t_load = 1'b1; t_n = pre_q;
                end else begin
                    state_d = ST_IDLE; done_set = 1'b1;
                end
            end
            ST_WAIT: if (byte_go) state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) begin
                if (left_q != LEN_W'(1)) begin
                    if (gap_q != '0) begin
                        state_d = ST_GAP; t_load = 1'b1; t_n = gap_q;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end else if (pre_q != '0) begin
                    state_d = ST_PRE; t_load = 1'b1; t_n = pre_q;
                end else begin
                    state_d = ST_IDLE; done_set = 1'b1;
                end
            end
            ST_GAP: if (t_expire) state_d = ST_WAIT;
            ST_PRE: if (t_expire) begin
                state_d = ST_IDLE; done_set = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured configuration, byte count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_WRITE;
            sel_q      <= '0;
            rate_q     <= '0;
            cpol_q     <= 1'b0;
            cpha_q     <= 1'b0;
            rtr_high_q <= 1'b0;
            post_q     <= '0;
            gap_q      <= '0;
            pre_q      <= '0;
            left_q     <= '0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            done       <= 1'b0;
        end else begin
            state_q  <= state_d;
            done     <= done_set;
            rx_valid <= sh_done && reads;
            if (sh_done) begin
                rx_data <= sh_rx;
                left_q  <= left_q - LEN_W'(1);
            end
            if (accept) begin
                mode_q     <= xfer_mode_e'(cmd_mode);
                sel_q      <= cfg_cs_sel;
                rate_q     <= cfg_rate;
                cpol_q     <= cfg_cpol;
                cpha_q     <= cfg_cpha;
                rtr_high_q <= cfg_rtr_high;
                post_q     <= cfg_dly_post;
                gap_q      <= cfg_dly_byte;
                pre_q      <= cfg_dly_pre;
                left_q     <= cmd_len;
            end
        end
    end

    // One decoder term per chip-select output.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign cs_n[gi] = !((state_q != ST_IDLE) && (sel_q == SEL_W'(gi)));
    end

    spi_dm_timer #(
        .TICK_CYCLES(TICK_CYCLES),
        .N_W        (DLY_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .load_n(t_n),
        .expire(t_expire)
    );

    spi_dm_shifter #(
        .BASE_HALF(BASE_HALF),
        .RATE_W   (3)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (byte_go),
        .tx_byte(needs_tx ? tx_data : 8'h00),
        .cpol   (cpol_q),
        .cpha   (cpha_q),
        .rate   (rate_q),
        .miso   (miso),
        .sck    (sck),
        .mosi   (mosi),
        .rx_byte(sh_rx),
        .busy   (sh_busy),
        .done   (sh_done)
    );

    spi_dm_activity #(
        .HALF_CYCLES(ACT_HALF_CYCLES)
    ) u_act (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (!cmd_ready),
        .act  (activity)
    );
endmodule

// File: rtl/spi_delay_master_chk.sv
// Cycle-by-cycle checker for spi_delay_master, attached with bind.
module spi_delay_master_chk #(
    parameter int NUM_CS = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic              cpol_q,
    input logic              cmd_ready,
    input logic              activity,
    input logic              done,
    input logic              rx_valid,
    input logic              tx_ready,
    input logic [1:0]        mode_q
);
    // R2: never more than one chip select low.
    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4: idle clock level follows the captured polarity.
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (sck == cpol_q));

    // R4: SCK moves only during a transfer (polarity reloads excluded).
    assert_sck_busy_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && $stable(cpol_q)) |-> !cmd_ready);

    // R9: activity is high across idle stretches.
    assert_activity_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && $past(cmd_ready)) |-> activity);

    // R10: done is a lone pulse.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done coincides with chip-select release and idle.
    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((&cs_n) && cmd_ready));

    // R7: write mode never returns a received byte.
    assert_no_rx_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (mode_q != 2'd0));

    // R7: outgoing bytes are only requested during a transfer.
    assert_tx_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !cmd_ready);
endmodule

bind spi_delay_master spi_delay_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .cpol_q   (cpol_q),
    .cmd_ready(cmd_ready),
    .activity (activity),
    .done     (done),
    .rx_valid (rx_valid),
    .tx_ready (tx_ready),
    .mode_q   (mode_q)
);

// File: tb/spi_delay_master_bench.sv
// Scoreboard bench: the driver queues expected MOSI/RX bytes, a slave model
// and monitor compare what the design produces. Timing is sampled at negedge.
module spi_delay_master_bench;
    localparam int NUM_CS = 11;
    localparam int TICK   = 5;
    localparam int BHALF  = 2;
    localparam int AHALF  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_mode = 2'd0;
    logic [15:0] cmd_len = '0;
    logic [3:0]  cfg_cs_sel = '0;
    logic [2:0]  cfg_rate = '0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_rtr_high = 1'b1;
    logic [15:0] cfg_dly_post = '0, cfg_dly_byte = '0, cfg_dly_pre = '0;
    logic        tx_valid = 1'b0, tx_ready;
    logic [7:0]  tx_data = '0;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rtr_in = 1'b1;
    logic        miso = 1'b0;
    logic        sck, mosi, activity, done;
    logic [NUM_CS-1:0] cs_n;

    always #5 clk = ~clk;

    spi_delay_master #(
        .NUM_CS(NUM_CS), .SEL_W(4), .LEN_W(16), .DLY_W(16),
        .BASE_HALF(BHALF), .TICK_CYCLES(TICK), .ACT_HALF_CYCLES(AHALF)
    ) u_spi_delay_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_len(cmd_len), .cfg_cs_sel(cfg_cs_sel),
        .cfg_rate(cfg_rate), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_rtr_high(cfg_rtr_high), .cfg_dly_post(cfg_dly_post),
        .cfg_dly_byte(cfg_dly_byte), .cfg_dly_pre(cfg_dly_pre),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rtr_in(rtr_in), .miso(miso),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .activity(activity), .done(done)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [7:0] tx_q[$], exp_mosi[$], exp_rx[$];
    logic b_cpol = 1'b0, b_cpha = 1'b0;
    int ecount = 0, mcnt = 0;
    logic [7:0] mbits = '0;
    int t_start, t_first, t_second, t_e15, t_e16, t_last, t_csfall, t_csrise;
    int t_tog, act_togs = 0, act_bad = 0;
    bit have_tog = 0, prev_rdy = 1, prev_sck = 0, prev_cslow = 0, acc_pend = 0;
    int salt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'hC3 ^ 8'(k * 37);
    endfunction

    // Slave drives the bit for the next sample point.
    function automatic logic slave_bit(input int ec);
        int s;
        s = b_cpha ? ((ec == 0) ? 0 : (ec - 1) / 2) : ec / 2;
        return pat(s / 8)[7 - (s % 8)];
    endfunction

    // Outgoing byte feeder: pop after the edge that accepted the byte.
    always @(negedge clk) begin
        if (acc_pend) void'(tx_q.pop_front());
        tx_valid = (tx_q.size() > 0);
        tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
        acc_pend = tx_valid && tx_ready;
    end

    // Slave model, edge timing, chip-select timing, activity and RX monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cmd_ready && prev_rdy) begin
                ecount = 0; mcnt = 0; t_start = cyc; have_tog = 0;
                act_togs = 0; prev_sck = sck;
                miso = slave_bit(0);
            end else if (!cmd_ready && (sck != prev_sck)) begin
                if ((b_cpha ? (sck == b_cpol) : (sck != b_cpol))) begin
                    mbits = {mbits[6:0], mosi};
                    mcnt++;
                    if (mcnt == 8) begin
                        mcnt = 0;
                        if (exp_mosi.size() == 0) check(0, "R5 unexpected MOSI byte", mbits, -1);
                        else begin
                            logic [7:0] e;
                            e = exp_mosi.pop_front();
                            check(mbits == e, "R5 R7 MOSI byte", mbits, e);
                        end
                    end
                end
                if (ecount == 0) t_first = cyc;
                if (ecount == 1) t_second = cyc;
                if (ecount == 15) t_e15 = cyc;
                if (ecount == 16) t_e16 = cyc;
                t_last = cyc;
                ecount++;
                prev_sck = sck;
                miso = slave_bit(ecount);
            end
            if (cmd_ready) prev_sck = sck;
            if (!(&cs_n) && !prev_cslow) t_csfall = cyc;
            if ((&cs_n) && prev_cslow) t_csrise = cyc;
            prev_cslow = !(&cs_n);
            if (!cmd_ready && prev_rdy == 0 && activity != u_act_prev) begin
                if (have_tog && (cyc - t_tog != AHALF)) act_bad++;
                t_tog = cyc; have_tog = 1; act_togs++;
            end
            if (rx_valid) begin
                if (exp_rx.size() == 0) check(0, "R7 unexpected RX byte", rx_data, -1);
                else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data == e, "R5 R7 RX byte", rx_data, e);
                end
            end
            prev_rdy = cmd_ready;
        end
        u_act_prev = activity;
    end
    logic u_act_prev = 1'b1;

    task automatic start_xfer(input logic [1:0] mode, input int len, input int sel,
                              input int rate, input logic cpol, input logic cpha,
                              input int post, input int gap, input int pre,
                              input logic rtrhi);
        b_cpol = cpol; b_cpha = cpha;
        for (int k = 0; k < len; k++) begin
            logic [7:0] d;
            d = 8'h5A ^ 8'(k * 19 + salt);
            if (mode == 2'd0 || mode == 2'd2) begin
                tx_q.push_back(d); exp_mosi.push_back(d);
            end else exp_mosi.push_back(8'h00);
            if (mode != 2'd0) exp_rx.push_back(pat(k));
        end
        salt = salt + 7;
        @(negedge clk);
        cmd_mode = mode; cmd_len = 16'(len); cfg_cs_sel = 4'(sel); cfg_rate = 3'(rate);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_dly_post = 16'(post);
        cfg_dly_byte = 16'(gap); cfg_dly_pre = 16'(pre); cfg_rtr_high = rtrhi;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        check((&cs_n) && cmd_ready, "R10 release with done", int'(cs_n), (1 << NUM_CS) - 1);
        @(negedge clk);
        check(!done, "R10 done single cycle", done, 0);
        check(exp_mosi.size() == 0 && exp_rx.size() == 0, "R7 scoreboard drained",
              exp_mosi.size() + exp_rx.size(), 0);
    endtask

    task automatic run_tests();
        int a0, b0, c0;
        logic [NUM_CS-1:0] want;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R9: reset state
        check(cmd_ready, "R1 idle after reset", cmd_ready, 1);
        check(&cs_n, "R2 no chip select after reset", int'(cs_n), (1 << NUM_CS) - 1);
        check(activity, "R9 activity high at reset", activity, 1);
        check(!rx_valid && !sck, "R4 quiet lines at reset", int'(sck), 0);

        // Baseline, zero delays (R3 R6 R2)
        start_xfer(2'd2, 2, 3, 0, 0, 0, 0, 0, 0, 1);
        want = ~(NUM_CS'(1) << 3);
        check(cs_n == want, "R2 selected chip select low", int'(cs_n), int'(want));
        wait_done();
        a0 = t_first - t_csfall; b0 = t_e16 - t_e15; c0 = t_csrise - t_last;
        check(t_second - t_first == BHALF, "R3 half period rate 0", t_second - t_first, BHALF);

        // R6: each delay adds N*TICK cycles
        start_xfer(2'd2, 2, 3, 0, 0, 0, 3, 2, 4, 1);
        wait_done();
        check(t_first - t_csfall - a0 == 3 * TICK, "R6 post-assert delay", t_first - t_csfall - a0, 3 * TICK);
        check(t_e16 - t_e15 - b0 == 2 * TICK, "R6 inter-byte delay", t_e16 - t_e15 - b0, 2 * TICK);
        check(t_csrise - t_last - c0 == 4 * TICK, "R6 pre-deassert delay", t_csrise - t_last - c0, 4 * TICK);

        // R4 R5: all four clock modes
        for (int m = 0; m < 4; m++) begin
            start_xfer(2'd2, 3, m, 1, m[1], m[0], 0, 1, 0, 1);
            wait_done();
            check(t_second - t_first == 2 * BHALF, "R3 half period rate 1", t_second - t_first, 2 * BHALF);
            check(sck == m[1], "R4 sck idles at polarity", sck, m[1]);
        end

        // R7: write-only and read-only
        start_xfer(2'd0, 2, 0, 0, 0, 0, 0, 0, 0, 1);
        wait_done();
        start_xfer(2'd1, 2, 1, 0, 1, 1, 0, 0, 0, 1);
        wait_done();

        // R3: slowest rate
        start_xfer(2'd1, 1, 2, 7, 0, 0, 0, 0, 0, 1);
        wait_done();
        check(t_second - t_first == BHALF << 7, "R3 half period rate 7", t_second - t_first, BHALF << 7);

        // R2: out-of-range select drives nothing
        start_xfer(2'd2, 1, NUM_CS, 0, 0, 0, 0, 0, 0, 1);
        check(&cs_n, "R2 out-of-range select", int'(cs_n), (1 << NUM_CS) - 1);
        wait_done();

        // R1: configuration changes after accept are ignored
        start_xfer(2'd2, 2, 6, 0, 0, 0, 0, 0, 0, 1);
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_rate = 3'd3; cfg_cs_sel = 4'd5;
        repeat (4) @(negedge clk);
        want = ~(NUM_CS'(1) << 6);
        check(cs_n == want, "R1 select held after change", int'(cs_n), int'(want));
        wait_done();
        check(t_second - t_first == BHALF, "R1 rate held after change", t_second - t_first, BHALF);

        // R8: gated read with active-low ready-to-read
        rtr_in = 1'b1;
        start_xfer(2'd3, 2, 4, 0, 0, 0, 0, 0, 0, 0);
        repeat (60) @(negedge clk);
        check(ecount == 0 && !(&cs_n), "R8 waits with CS asserted", ecount, 0);
        check(sck == 1'b0, "R8 sck idle while waiting", sck, 0);
        rtr_in = 1'b0;
        while (ecount == 0) @(negedge clk);
        rtr_in = 1'b1;
        repeat (200) @(negedge clk);
        check(ecount == 16, "R8 byte completes then pauses", ecount, 16);
        rtr_in = 1'b0;
        wait_done();
        check(ecount == 32, "R8 resumes after reassert", ecount, 32);
        rtr_in = 1'b1;

        // R11: zero-length command
        start_xfer(2'd2, 0, 1, 0, 0, 0, 3, 0, 2, 1);
        wait_done();
        check(ecount == 0, "R11 no clock edges", ecount, 0);
        check(t_csrise - t_csfall == 5 * TICK, "R11 select window", t_csrise - t_csfall, 5 * TICK);

        // R9: activity toggles while busy, high after
        start_xfer(2'd2, 2, 0, 4, 0, 0, 0, 0, 0, 1);
        wait_done();
        check(act_togs >= 4, "R9 activity toggles while busy", act_togs, 4);
        check(act_bad == 0, "R9 toggle spacing", act_bad, 0);
        @(negedge clk);
        check(activity, "R9 activity high when idle", activity, 1);
    endtask

    initial begin
        bit wd = 0;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule